// File: doc/BRIEF.md
# Configuration Register Integrity Checker

This block holds a small bank of control registers and watches them for internal upsets. Each data register keeps one even-parity bit. The parity is computed when the register is written and compared against the stored value on every clock. Each enable control is kept as two rails, a true rail and a complement rail. A control whose rails stop disagreeing is treated as corrupted. Each kind of fault sets its own sticky flag.

Software can test the checker through a fault register. That register inverts stored parity bits or complement rails, but only while both the receive and transmit controls are off.

The single-error flag reports any parity fault seen since the last status read. The event-error flag drops when the enable controls are rewritten into a clean state, or when software asks for a clear through the fault register.

Top module: `cfg_integrity_guard`

## Requirements
- R1: After reset, every data register reads 0, every enable control is off (true rail 0, complement rail 1), and both error flags are low.
- R2: Writing address i, with i below NREG, stores wr_data into register i. The value shows on cfg_q[i*DW +: DW] after the write edge. A write to any address above NREG+1 changes no register, no control and no flag.
- R3: A write to address NREG drives the enable controls. In wr_data, bit 2p turns control p on and bit 2p+1 turns it off. If both bits are set, or neither is, control p keeps its value. Control 0 is rx_en and control 1 is tx_en.
- R4: A write to a data register also stores that value's even parity. The stored parity is checked on every cycle. A mismatch raises single_err at the same clock edge that creates the mismatch.
- R5: Once single_err is set, it stays high until stat_rd is pulsed. A pulse on stat_rd clears the flag only if no parity mismatch remains at that edge.
- R6: A write of wr_data bit 0 = 1 to the fault register (address NREG+1) inverts the stored parity of every data register, but only while rx_en and tx_en are both low. Rewriting a data register restores its parity.
- R7: A write of fault-register bit 2 = 1 inverts the complement rail of every control, under the same idle gating as R6. Any control whose rails are equal raises event_err at that edge.
- R8: event_err clears under two conditions, provided every control is complementary after the edge: a write to address NREG, or a fault-register write with bit 1 = 1. If any control is still corrupt, event_err stays high.
- R9: A fault-register write made while rx_en or tx_en is high changes neither the stored parity nor the control rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| stat_rd | input | 1 | Status read strobe, clears single_err |
| cfg_q | output | NREG*DW | Stored data registers, register i at bits i*DW +: DW |
| ctl_on | output | NPAIR | True rails of the enable controls |
| rx_en | output | 1 | Receive enable (control 0) |
| tx_en | output | 1 | Transmit enable (control 1) |
| single_err | output | 1 | Sticky parity-fault flag |
| event_err | output | 1 | Enable-control corruption flag |

## Verification
The bench makes a fault request while only receive is enabled and again while only transmit is enabled. A design that gated injection on one path alone, or not at all, would raise single_err or event_err in those tests.

It pulses stat_rd while parity is still corrupt. A design that let the read win over a live mismatch would drop single_err and hide the fault.

It repairs the controls only partly, and also sends a software clear while corruption remains. A design that cleared event_err on any pair write, or on the clear bit alone, would report a clean state too early.

It writes controls with both action bits set and with neither set. A design that let one bit win would change rx_en.

// File: rtl/cfg_integrity_guard.sv
module cfg_integrity_guard #(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int NPAIR = 3,
  localparam int AW   = $clog2(NREG + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               stat_rd,
  output logic [NREG*DW-1:0] cfg_q,
  output logic [NPAIR-1:0]   ctl_on,
  output logic               rx_en,
  output logic               tx_en,
  output logic               single_err,
  output logic               event_err
);

  logic [DW-1:0]    cfg_r [NREG];
  logic [DW-1:0]    cfg_n [NREG];
  logic [NREG-1:0]  par_r, par_n;
  logic [NPAIR-1:0] on_r, off_r, on_n, off_n;
  logic             se_r, ev_r;

  wire pair_hit = wr_en && (wr_addr == AW'(NREG));
  wire flt_hit  = wr_en && (wr_addr == AW'(NREG + 1));
  wire idle     = !on_r[0] && !on_r[1];
  wire inj_ok   = flt_hit && idle;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cfg_n[i] = cfg_r[i];
      par_n[i] = par_r[i];
      if (wr_en && (wr_addr == AW'(i))) begin
        cfg_n[i] = wr_data;
        par_n[i] = ^wr_data;
      end else if (inj_ok && wr_data[0]) begin
        par_n[i] = ~par_r[i];
      end
    end
    for (int p = 0; p < NPAIR; p++) begin
      on_n[p]  = on_r[p];
      off_n[p] = off_r[p];
      if (pair_hit && (wr_data[2*p] ^ wr_data[2*p+1])) begin
        on_n[p]  = wr_data[2*p];
        off_n[p] = ~wr_data[2*p];
      end else if (inj_ok && wr_data[2]) begin
        off_n[p] = ~off_r[p];
      end
    end
  end

  logic par_bad_n;
  always_comb begin
    par_bad_n = 1'b0;
    for (int i = 0; i < NREG; i++) par_bad_n = par_bad_n | (par_n[i] ^ (^cfg_n[i]));
  end
  wire pair_bad_n = |(~(on_n ^ off_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg_r[i] <= '0;
      par_r <= '0;
      on_r  <= '0;
      off_r <= '1;
      se_r  <= 1'b0;
      ev_r  <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) cfg_r[i] <= cfg_n[i];
      par_r <= par_n;
      on_r  <= on_n;
      off_r <= off_n;
      se_r  <= par_bad_n | (se_r & ~stat_rd);
      ev_r  <= pair_bad_n | (ev_r & ~(pair_hit | (flt_hit & wr_data[1])));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_q[g*DW +: DW] = cfg_r[g];
  end
  assign ctl_on     = on_r;
  assign rx_en      = on_r[0];
  assign tx_en      = on_r[1];
  assign single_err = se_r;
  assign event_err  = ev_r;

  logic [NREG-1:0] chk_par;
  for (genvar g = 0; g < NREG; g++) begin : g_chk
    assign chk_par[g] = par_r[g] ^ (^cfg_r[g]);
  end
  wire chk_pair = (on_r & off_r) != '0 || (~on_r & ~off_r) != '0;

  initial assert (NPAIR >= 2 && DW >= 2*NPAIR && DW >= 3);

  a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_par != '0) |-> single_err);
  a_r7_pair_flag: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pair |-> event_err);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (single_err && !stat_rd) |=> single_err);
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_hit && (rx_en || tx_en)) |=> ($stable(par_r) && $stable(off_r)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
  a_r3_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hit && wr_data[0] && !wr_data[1]) |=> rx_en);

endmodule

// File: tb/cfg_integrity_guard_test.sv
module cfg_integrity_guard_test;
  localparam int NREG = 4, DW = 8, NPAIR = 3, AW = $clog2(NREG + 2);
  localparam logic [AW-1:0] A_PAIR = AW'(NREG), A_FLT = AW'(NREG + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, stat_rd = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NREG*DW-1:0] cfg_q;
  logic [NPAIR-1:0] ctl_on;
  logic rx_en, tx_en, single_err, event_err;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cfg_integrity_guard #(.NREG(NREG), .DW(DW), .NPAIR(NPAIR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .cfg_q(cfg_q), .ctl_on(ctl_on), .rx_en(rx_en), .tx_en(tx_en),
    .single_err(single_err), .event_err(event_err));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 cfg", 64'(cfg_q), 0);
    chk("R1 ctl", 64'(ctl_on), 0);
    chk("R1 flags", {62'd0, single_err, event_err}, 0);
  endtask

  task automatic t_write();
    wr(0, 8'h5A); wr(1, 8'hC3); wr(2, 8'h07); wr(3, 8'hFF);
    chk("R2 store", 64'(cfg_q), 64'hFF07C35A);
    chk("R4 clean parity", 64'(single_err), 0);
    wr(AW'(7), 8'h11);
    chk("R2 bad addr cfg", 64'(cfg_q), 64'hFF07C35A);
    chk("R2 bad addr ctl", 64'(ctl_on), 0);
  endtask

  task automatic t_pairs();
    wr(A_PAIR, 8'h01);
    chk("R3 rx on", {62'd0, rx_en, tx_en}, 2'b10);
    wr(A_PAIR, 8'h03);
    chk("R3 both bits keep", 64'(rx_en), 1);
    wr(A_PAIR, 8'h00);
    chk("R3 neither keeps", 64'(rx_en), 1);
    wr(A_PAIR, 8'h06);
    chk("R3 rx off tx on", {62'd0, rx_en, tx_en}, 2'b01);
    chk("R3 no event", 64'(event_err), 0);
  endtask

  task automatic t_blocked();
    wr(A_FLT, 8'h05);
    chk("R9 tx busy parity", 64'(single_err), 0);
    chk("R9 tx busy rails", 64'(event_err), 0);
    wr(A_PAIR, 8'h09);
    wr(A_FLT, 8'h05);
    chk("R9 rx busy parity", 64'(single_err), 0);
    wr(A_PAIR, 8'h0A);
    chk("R9 idle again no flag", {62'd0, single_err, event_err}, 0);
  endtask

  task automatic t_parity();
    wr(A_FLT, 8'h01);
    chk("R6 inject flags", 64'(single_err), 1);
    chk("R6 data kept", 64'(cfg_q), 64'hFF07C35A);
    rd_stat();
    chk("R5 read with live fault", 64'(single_err), 1);
    wr(0, 8'h5A); wr(1, 8'hC3); wr(2, 8'h07);
    rd_stat();
    chk("R6 partial repair", 64'(single_err), 1);
    wr(3, 8'hFF);
    chk("R5 sticky until read", 64'(single_err), 1);
    rd_stat();
    chk("R5 read clears", 64'(single_err), 0);
  endtask

  task automatic t_event();
    wr(A_FLT, 8'h04);
    chk("R7 pair break", 64'(event_err), 1);
    chk("R7 parity untouched", 64'(single_err), 0);
    wr(A_FLT, 8'h02);
    chk("R8 clear while corrupt", 64'(event_err), 1);
    wr(A_PAIR, 8'h02);
    chk("R8 partial rewrite", 64'(event_err), 1);
    wr(A_PAIR, 8'h28);
    chk("R8 full rewrite clears", 64'(event_err), 0);
    chk("R8 controls off", 64'(ctl_on), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_write();
    t_pairs();
    t_blocked();
    t_parity();
    t_event();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule